// File: doc/BRIEF.md
# Two-Level Interrupt Priority Selector

This block keeps the pending and enable state for three interrupt sources (machine software, supervisor software and supervisor timer) and watches a host-message word. From the hart's current privilege level and its global interrupt enable, it decides every cycle whether an interrupt should be taken, and which one. It reports the result as a valid flag and a cause word whose top bit marks it as an interrupt.

Software reaches the state through a small register port. The port offers four views: machine pending, machine enable, supervisor pending and supervisor enable. Each view has its own read mask and its own write mask. Hardware events also change the pending bits: an inter-processor interrupt, a timer match, and a timer-compare rewrite. The selection is purely combinational from the registered state and the level inputs. It therefore follows a register update on the same clock edge.

Top module: `irq_prio_sel`

## Requirements
- R1: While reset is asserted, and after it is released, all pending and enable bits read back zero in every view, `irq_valid_o` is 0 and `irq_cause_o` is 0.
- R2: A source is active only when its pending bit and its enable bit are both 1. With no active source and a zero host word, `irq_valid_o` is 0.
- R3: Privilege is encoded user=0, supervisor=1, machine=3 (2 is reserved) and compared numerically. The machine group (machine software, host) is eligible when the privilege is below 3, or when it equals 3 and `irq_gie_i` is 1.
- R4: The supervisor group (supervisor software, supervisor timer) is eligible when the privilege is below 1, or when it equals 1 and `irq_gie_i` is 1.
- R5: Among the eligible candidates, selection follows a fixed order: machine software, then a nonzero host word, then supervisor software, then supervisor timer.
- R6: When `irq_valid_o` is 1, `irq_cause_o` has bit 31 set and the code in bits 1:0 (software=0, timer=1, host=2), with all other bits zero. When `irq_valid_o` is 0, `irq_cause_o` is zero.
- R7: State bits sit at these positions: bit 0 is supervisor software, bit 1 is machine software, bit 2 is supervisor timer. View select codes are 0 machine pending, 1 machine enable, 2 supervisor pending and 3 supervisor enable. A write to view 0 updates bits 1:0 and leaves bit 2 unchanged.
- R8: A write to view 1 updates all three enable bits. Views 0 and 1 read back all three bits.
- R9: Views 2 and 3 read back the pending or enable bits masked to bits 0 and 2. Bit 1 always reads 0 in those views.
- R10: A write to view 2 updates only pending bit 0. A write to view 3 updates enable bits 0 and 2 and leaves enable bit 1 unchanged.
- R11: `ipi_i` sets pending bit 1 on the next edge. It wins over a write in the same cycle that would clear that bit.
- R12: `tmr_set_i` sets pending bit 2 and `tmr_clr_i` clears it. When both are high in the same cycle, the bit ends up set.
- R13: A nonzero `host_msg_i` is a candidate regardless of any enable bit. At user level it always produces `irq_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| priv_i | input | 2 | Current privilege level |
| irq_gie_i | input | 1 | Global interrupt enable of the current level |
| host_msg_i | input | 32 | Host message word; nonzero means a host interrupt is pending |
| ipi_i | input | 1 | Inter-processor interrupt event |
| tmr_set_i | input | 1 | Timer match event, sets supervisor timer pending |
| tmr_clr_i | input | 1 | Timer compare rewrite, clears supervisor timer pending |
| csr_we_i | input | 1 | Write strobe of the register port |
| csr_sel_i | input | 2 | View select of the register port |
| csr_wdata_i | input | 3 | Write data of the register port |
| csr_rdata_o | output | 3 | Read data of the selected view |
| irq_valid_o | output | 1 | An interrupt should be taken |
| irq_cause_o | output | 32 | Cause word of the selected interrupt |

## Verification
Two sources can update the same pending bit in one cycle. A software write through the register port can collide with a hardware event on the same bit: an IPI against a machine-view write that clears machine software pending, or a timer set against a timer clear. The bench drives these collisions on the same falling edge and reads the bit back through the machine pending view after the next rising edge. A set must never be lost. The full sweep also runs the timer set or clear in the same cycle as a machine-view write that tries to flip bit 2, which checks the write mask and the event path together.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam int SRC_N = 3;

  localparam int B_SSW = 0;
  localparam int B_MSW = 1;
  localparam int B_STM = 2;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    VIEW_M_PEND = 2'd0,
    VIEW_M_EN   = 2'd1,
    VIEW_S_PEND = 2'd2,
    VIEW_S_EN   = 2'd3
  } view_e;

  localparam logic [SRC_N-1:0] M_PEND_WMASK = 3'b011;
  localparam logic [SRC_N-1:0] M_EN_WMASK   = 3'b111;
  localparam logic [SRC_N-1:0] S_PEND_WMASK = 3'b001;
  localparam logic [SRC_N-1:0] S_EN_WMASK   = 3'b101;
  localparam logic [SRC_N-1:0] S_READ_MASK  = 3'b101;

  localparam int CODE_W = 2;
  localparam logic [CODE_W-1:0] CODE_SW   = 2'd0;
  localparam logic [CODE_W-1:0] CODE_TMR  = 2'd1;
  localparam logic [CODE_W-1:0] CODE_HOST = 2'd2;

endpackage

// File: rtl/irq_view_port.sv
module irq_view_port
  import irq_prio_pkg::*;
(
  input  logic [1:0]       sel_i,
  input  logic             we_i,
  input  logic [SRC_N-1:0] wdata_i,
  input  logic [SRC_N-1:0] pend_q_i,
  input  logic [SRC_N-1:0] en_q_i,
  output logic             pend_we_o,
  output logic             en_we_o,
  output logic [SRC_N-1:0] wmask_o,
  output logic [SRC_N-1:0] wval_o,
  output logic [SRC_N-1:0] rdata_o
);

  always_comb begin
    pend_we_o = 1'b0;
    en_we_o   = 1'b0;
    wmask_o   = '0;
    rdata_o   = '0;
    case (view_e'(sel_i))
      VIEW_M_PEND: begin
        rdata_o   = pend_q_i;
        pend_we_o = we_i;
        wmask_o   = M_PEND_WMASK;
      end
      VIEW_M_EN: begin
        rdata_o = en_q_i;
        en_we_o = we_i;
        wmask_o = M_EN_WMASK;
      end
      VIEW_S_PEND: begin
        rdata_o   = pend_q_i & S_READ_MASK;
        pend_we_o = we_i;
        wmask_o   = S_PEND_WMASK;
      end
      default: begin
        rdata_o = en_q_i & S_READ_MASK;
        en_we_o = we_i;
        wmask_o = S_EN_WMASK;
      end
    endcase
  end

  assign wval_o = wdata_i;

endmodule

// File: rtl/irq_src_regs.sv
module irq_src_regs
  import irq_prio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend_we_i,
  input  logic             en_we_i,
  input  logic [SRC_N-1:0] wmask_i,
  input  logic [SRC_N-1:0] wval_i,
  input  logic             ipi_i,
  input  logic             tmr_set_i,
  input  logic             tmr_clr_i,
  output logic [SRC_N-1:0] pend_q_o,
  output logic [SRC_N-1:0] en_q_o
);

  logic [SRC_N-1:0] hw_set;
  logic [SRC_N-1:0] hw_clr;
  logic [SRC_N-1:0] pend_d;
  logic [SRC_N-1:0] en_d;
  logic             pend_ce;
  logic             en_ce;

  always_comb begin
    hw_set        = '0;
    hw_clr        = '0;
    hw_set[B_MSW] = ipi_i;
    hw_set[B_STM] = tmr_set_i;
    hw_clr[B_STM] = tmr_clr_i;
  end

  for (genvar i = 0; i < SRC_N; i++) begin : g_bit
    logic sw_pend;
    assign sw_pend   = (pend_we_i && wmask_i[i]) ? wval_i[i] : pend_q_o[i];
    assign pend_d[i] = hw_set[i] | (~hw_clr[i] & sw_pend);
    assign en_d[i]   = (en_we_i && wmask_i[i]) ? wval_i[i] : en_q_o[i];
  end

  assign pend_ce = pend_we_i | ipi_i | tmr_set_i | tmr_clr_i;
  assign en_ce   = en_we_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q_o <= '0;
    end else if (pend_ce) begin
      pend_q_o <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q_o <= '0;
    end else if (en_ce) begin
      en_q_o <= en_d;
    end
  end

endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_prio_pkg::*;
#(
  parameter int CAUSE_W = 32,
  parameter int HOST_W  = 32
) (
  input  logic [SRC_N-1:0]  pend_i,
  input  logic [SRC_N-1:0]  en_i,
  input  logic [1:0]        priv_i,
  input  logic              gie_i,
  input  logic [HOST_W-1:0] host_i,
  output logic              valid_o,
  output logic [CAUSE_W-1:0] cause_o
);

  logic [SRC_N-1:0]  act;
  logic              host_nz;
  logic              m_elig;
  logic              s_elig;
  logic [CODE_W-1:0] code;

  assign act     = pend_i & en_i;
  assign host_nz = |host_i;
  assign m_elig  = (priv_i < PRIV_MACH)  || ((priv_i == PRIV_MACH)  && gie_i);
  assign s_elig  = (priv_i < PRIV_SUPER) || ((priv_i == PRIV_SUPER) && gie_i);

  always_comb begin
    valid_o = 1'b1;
    code    = CODE_SW;
    if (m_elig && act[B_MSW]) begin
      code = CODE_SW;
    end else if (m_elig && host_nz) begin
      code = CODE_HOST;
    end else if (s_elig && act[B_SSW]) begin
      code = CODE_SW;
    end else if (s_elig && act[B_STM]) begin
      code = CODE_TMR;
    end else begin
      valid_o = 1'b0;
    end
  end

  always_comb begin
    cause_o = '0;
    if (valid_o) begin
      cause_o[CAUSE_W-1]  = 1'b1;
      cause_o[CODE_W-1:0] = code;
    end
  end

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_prio_pkg::*;
#(
  parameter int CAUSE_W = 32,
  parameter int HOST_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         priv_i,
  input  logic               irq_gie_i,
  input  logic [HOST_W-1:0]  host_msg_i,
  input  logic               ipi_i,
  input  logic               tmr_set_i,
  input  logic               tmr_clr_i,
  input  logic               csr_we_i,
  input  logic [1:0]         csr_sel_i,
  input  logic [SRC_N-1:0]   csr_wdata_i,
  output logic [SRC_N-1:0]   csr_rdata_o,
  output logic               irq_valid_o,
  output logic [CAUSE_W-1:0] irq_cause_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic             pend_we;
  logic             en_we;
  logic [SRC_N-1:0] wmask;
  logic [SRC_N-1:0] wval;
  logic [SRC_N-1:0] pend_q;
  logic [SRC_N-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  irq_view_port u_view (
    .sel_i    (csr_sel_i),
    .we_i     (csr_we_i),
    .wdata_i  (csr_wdata_i),
    .pend_q_i (pend_q),
    .en_q_i   (en_q),
    .pend_we_o(pend_we),
    .en_we_o  (en_we),
    .wmask_o  (wmask),
    .wval_o   (wval),
    .rdata_o  (csr_rdata_o)
  );

  irq_src_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .pend_we_i(pend_we),
    .en_we_i  (en_we),
    .wmask_i  (wmask),
    .wval_i   (wval),
    .ipi_i    (ipi_i),
    .tmr_set_i(tmr_set_i),
    .tmr_clr_i(tmr_clr_i),
    .pend_q_o (pend_q),
    .en_q_o   (en_q)
  );

  irq_select #(
    .CAUSE_W(CAUSE_W),
    .HOST_W (HOST_W)
  ) u_sel (
    .pend_i (pend_q),
    .en_i   (en_q),
    .priv_i (priv_i),
    .gie_i  (irq_gie_i),
    .host_i (host_msg_i),
    .valid_o(irq_valid_o),
    .cause_o(irq_cause_o)
  );

endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
  import irq_prio_pkg::*;
#(
  parameter int CAUSE_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         priv,
  input logic               gie,
  input logic               host_nz,
  input logic               ipi,
  input logic               tset,
  input logic               tclr,
  input logic               we,
  input logic [1:0]         sel,
  input logic [SRC_N-1:0]   pend_q,
  input logic [SRC_N-1:0]   en_q,
  input logic               valid,
  input logic [CAUSE_W-1:0] cause
);

  AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (((pend_q & en_q) == '0) && !host_nz) |-> !valid); // R2

  AST_MACH_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((priv == 2'd3) && !gie) |-> !valid); // R3

  AST_CAUSE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (cause[CAUSE_W-1] && (cause[CAUSE_W-2:CODE_W] == '0) && (cause[CODE_W-1:0] != 2'd3))); // R6

  AST_CAUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (cause == '0)); // R6

  AST_M_PEND_KEEPS_TMR: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (sel == 2'd0) && !tset && !tclr) |=> (pend_q[B_STM] == $past(pend_q[B_STM]))); // R7

  AST_S_PEND_KEEPS_MSW: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (sel == 2'd2) && !ipi) |=> (pend_q[B_MSW] == $past(pend_q[B_MSW]))); // R10

  AST_IPI_SETS_MSW: assert property (@(posedge clk) disable iff (!rst_n)
    ipi |=> pend_q[B_MSW]); // R11

  AST_TMR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    tset |=> pend_q[B_STM]); // R12

  AST_TMR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (tclr && !tset) |=> !pend_q[B_STM]); // R12

  AST_USER_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    ((priv == 2'd0) && host_nz) |-> valid); // R13

endmodule

bind irq_prio_sel irq_prio_chk #(.CAUSE_W(CAUSE_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n_s),
  .priv   (priv_i),
  .gie    (irq_gie_i),
  .host_nz(|host_msg_i),
  .ipi    (ipi_i),
  .tset   (tmr_set_i),
  .tclr   (tmr_clr_i),
  .we     (csr_we_i),
  .sel    (csr_sel_i),
  .pend_q (pend_q),
  .en_q   (en_q),
  .valid  (irq_valid_o),
  .cause  (irq_cause_o)
);

// File: tb/irq_prio_sel_tb.sv
module irq_prio_sel_tb;

  logic        clk;
  logic        rst_n;
  logic [1:0]  priv;
  logic        gie;
  logic [31:0] host;
  logic        ipi;
  logic        tset;
  logic        tclr;
  logic        we;
  logic [1:0]  sel;
  logic [2:0]  wdata;
  logic [2:0]  rdata;
  logic        valid;
  logic [31:0] cause;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  irq_prio_sel u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .priv_i     (priv),
    .irq_gie_i  (gie),
    .host_msg_i (host),
    .ipi_i      (ipi),
    .tmr_set_i  (tset),
    .tmr_clr_i  (tclr),
    .csr_we_i   (we),
    .csr_sel_i  (sel),
    .csr_wdata_i(wdata),
    .csr_rdata_o(rdata),
    .irq_valid_o(valid),
    .irq_cause_o(cause)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // expected {valid, cause} from the priority rules
  function automatic logic [32:0] model(input logic [2:0] p, input logic [2:0] e,
                                        input logic [1:0] pv, input logic g, input logic h);
    logic [2:0] a;
    logic       m_el;
    logic       s_el;
    a    = p & e;
    m_el = (pv < 2'd3) || (pv == 2'd3 && g);
    s_el = (pv < 2'd1) || (pv == 2'd1 && g);
    if (m_el && a[1])      return {1'b1, 32'h8000_0000};
    else if (m_el && h)    return {1'b1, 32'h8000_0002};
    else if (s_el && a[0]) return {1'b1, 32'h8000_0000};
    else if (s_el && a[2]) return {1'b1, 32'h8000_0001};
    return 33'd0;
  endfunction

  task automatic wr(input logic [1:0] v, input logic [2:0] d);
    @(negedge clk);
    we = 1'b1; sel = v; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] v, input logic [2:0] exp);
    sel = v;
    #1;
    check(req, {29'd0, rdata}, {29'd0, exp});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; priv = 2'd0; gie = 1'b0; host = '0; ipi = 1'b0;
    tset = 1'b0; tclr = 1'b0; we = 1'b0; sel = 2'd0; wdata = '0;
    repeat (3) @(negedge clk);
    // R1: during reset
    #1;
    check("R1 valid in reset", {31'd0, valid}, 32'd0);
    check("R1 cause in reset", cause, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int v = 0; v < 4; v++) rd_check("R1 view after reset", 2'(v), 3'b000);
    host = 32'h1; priv = 2'd0;
    #1;
    // R13: host alone at user level, no enables
    check("R13 host valid", {31'd0, valid}, 32'd1);
    check("R13 host cause", cause, 32'h8000_0002);
    host = '0;

    // R11: IPI wins over a same-cycle clearing write
    wr(2'd0, 3'b010);
    rd_check("R7 set machine sw", 2'd0, 3'b010);
    @(negedge clk);
    we = 1'b1; sel = 2'd0; wdata = 3'b000; ipi = 1'b1;
    @(negedge clk);
    we = 1'b0; ipi = 1'b0;
    rd_check("R11 ipi beats write", 2'd0, 3'b010);
    wr(2'd0, 3'b000);
    rd_check("R7 clear machine sw", 2'd0, 3'b000);

    // R10: supervisor pending write touches only bit 0
    wr(2'd2, 3'b111);
    rd_check("R10 s pend write", 2'd0, 3'b001);
    wr(2'd1, 3'b000);
    wr(2'd3, 3'b111);
    rd_check("R10 s en write", 2'd1, 3'b101);
    wr(2'd1, 3'b010);
    wr(2'd3, 3'b000);
    rd_check("R10 s en keeps bit1", 2'd1, 3'b010);

    // R12: set and clear together, then clear alone
    @(negedge clk);
    tset = 1'b1; tclr = 1'b1;
    @(negedge clk);
    tset = 1'b0; tclr = 1'b0;
    rd_check("R12 set wins", 2'd0, 3'b101);
    @(negedge clk);
    tclr = 1'b1;
    @(negedge clk);
    tclr = 1'b0;
    rd_check("R12 clear", 2'd0, 3'b001);

    // exhaustive sweep over pending, enable, privilege, gie, host
    for (int p = 0; p < 8; p++) begin
      for (int e = 0; e < 8; e++) begin
        logic [2:0] pp;
        logic [2:0] ee;
        pp = 3'(p);
        ee = 3'(e);
        @(negedge clk);
        we = 1'b1; sel = 2'd1; wdata = ee;
        @(negedge clk);
        sel = 2'd0; wdata = {~pp[2], pp[1:0]}; tset = pp[2]; tclr = ~pp[2];
        @(negedge clk);
        we = 1'b0; tset = 1'b0; tclr = 1'b0;
        rd_check("R7 m pend view", 2'd0, pp);
        rd_check("R8 m en view", 2'd1, ee);
        rd_check("R9 s pend view", 2'd2, pp & 3'b101);
        rd_check("R9 s en view", 2'd3, ee & 3'b101);
        for (int pv = 0; pv < 4; pv++) begin
          for (int g = 0; g < 2; g++) begin
            for (int h = 0; h < 2; h++) begin
              logic [32:0] m;
              priv = 2'(pv); gie = 1'(g);
              host = (h != 0) ? 32'h8000_0000 : 32'h0;
              m = model(pp, ee, 2'(pv), 1'(g), 1'(h));
              #1;
              check("R2 R3 R4 R13 valid", {31'd0, valid}, {31'd0, m[32]});
              check("R5 R6 cause", cause, m[31:0]);
            end
          end
        end
        host = '0;
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule